// File: doc/BRIEF.md
# Command Packet Word Assembler

This block sits at the entry of a drawing engine's command path. It takes a stream of 32-bit command words on a valid/ready port and groups them into packets. The top byte of the first word of a packet is its opcode. A fixed decode of that opcode gives the number of further words the packet carries. The block gathers the whole packet into a buffer of up to twelve slots. When the last word arrives, it raises a one-cycle dispatch strobe. During that strobe the opcode, the word count and every slot are presented together to the execution stage.

Two abort paths drop a half-collected packet:
- a plain flush pulse;
- a control strobe whose 32-bit argument must equal one key value before it has any effect.

While an image-transfer mode is active, accepted words bypass the assembler and appear on a divert port. They leave the packet state untouched.

Top module: `cmd_packet_assembler`

## Requirements
- R1: The opcode is bits 31:24 of a packet's first word. That word is held in slot 0 (`disp_words[31:0]`), and `disp_opcode` equals its top byte during dispatch.
- R2: The number of extra words per opcode is as follows. Every other opcode has 0.

  | Opcodes | Extra words |
  |---|---|
  | 0x3C–0x3F | 11 |
  | 0x2C–0x2F and 0x34–0x37 | 8 |
  | 0x38–0x3B | 7 |
  | 0x24–0x27 | 6 |
  | 0x30–0x33 | 5 |
  | 0x28–0x2B and 0x58–0x5F | 4 |
  | 0x20–0x23, 0x48–0x53, 0x64–0x67 and 0x80 | 3 |
  | 0x02, 0x40–0x43, 0x60–0x63, 0xA0 and 0xC0 | 2 |
  | 0x6C–0x6F, 0x74–0x77 and 0x7C–0x7F | 2 |
  | 0x68–0x6B, 0x70–0x73 and 0x78–0x7B | 1 |
- R3: An opcode with zero extra words dispatches in the cycle after its single word is accepted, with `disp_count` = 1.
- R4: The words following a header are stored in arrival order in slots 1, 2 and so on. The dispatch strobe rises in the cycle after the last of them is accepted.
- R5: `disp_valid` is high for exactly one cycle per packet, and `in_ready` is low in that cycle and high in every other cycle after reset.
- R6: A `flush` pulse cancels any pending packet, so the next word taken is a header. A word accepted in the same cycle as `flush` is itself treated as a header.
- R7: A `ctl_valid` strobe aborts like `flush` only when `ctl_arg` is exactly 0x04000000. Any other argument, or the key without `ctl_valid`, leaves the pending packet unchanged.
- R8: With `xfer_active` high, accepted words appear on `div_valid`/`div_word` in the same cycle. Those words are neither stored nor counted toward a pending packet.
- R9: After a synchronous reset no packet is pending, `disp_valid` is 0, `in_ready` is 1 and all slots read 0.
- R10: During dispatch `disp_count` equals the extra-word count of `disp_opcode` plus one.
- R11: Slots at or beyond `disp_count` read 0 during dispatch, because a new header clears every slot above slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Word accepted when high together with in_valid |
| in_word | input | WORD_W | Command word |
| xfer_active | input | 1 | Image-transfer mode: divert accepted words |
| flush | input | 1 | Abort pending packet |
| ctl_valid | input | 1 | Control strobe |
| ctl_arg | input | 32 | Control argument; aborts only on the key value |
| div_valid | output | 1 | Diverted word valid |
| div_word | output | WORD_W | Diverted word |
| disp_valid | output | 1 | One-cycle packet dispatch strobe |
| disp_opcode | output | 8 | Opcode of dispatched packet |
| disp_count | output | $clog2(MAX_WORDS+1) | Words in dispatched packet |
| disp_words | output | MAX_WORDS*WORD_W | Packet slots, slot k at bits k*WORD_W upward |

## Verification
An abort and an accepted word can land in the same cycle, and so can a diverted word and a pending abort. The bench raises `flush` together with `in_valid` in the middle of a packet. It expects that word to open a fresh packet, so the later dispatch carries the new opcode and the full new length. The bench also sends the abort key with and without `ctl_valid` and with a near-miss argument, and checks the resulting dispatch timing against a behavioural model on every clock.

// File: rtl/cpa_pkg.sv
package cpa_pkg;

   localparam int unsigned OPC_W = 8;
   localparam int unsigned LEN_W = 4;

   typedef logic [OPC_W-1:0] opc_t;
   typedef logic [LEN_W-1:0] len_t;

   // extra words that follow a header carrying opcode op
   function automatic len_t cpa_extra_words(input opc_t op);
      len_t n;
      n = '0;
      case (op) inside
         8'h02:                          n = 4'd2;
         [8'h20:8'h23]:                  n = 4'd3;
         [8'h24:8'h27]:                  n = 4'd6;
         [8'h28:8'h2B]:                  n = 4'd4;
         [8'h2C:8'h2F], [8'h34:8'h37]:   n = 4'd8;
         [8'h30:8'h33]:                  n = 4'd5;
         [8'h38:8'h3B]:                  n = 4'd7;
         [8'h3C:8'h3F]:                  n = 4'd11;
         [8'h40:8'h43], [8'h60:8'h63]:   n = 4'd2;
         [8'h48:8'h53], [8'h64:8'h67]:   n = 4'd3;
         [8'h58:8'h5F]:                  n = 4'd4;
         [8'h68:8'h6B], [8'h70:8'h73],
         [8'h78:8'h7B]:                  n = 4'd1;
         [8'h6C:8'h6F], [8'h74:8'h77],
         [8'h7C:8'h7F]:                  n = 4'd2;
         8'h80:                          n = 4'd3;
         8'hA0, 8'hC0:                   n = 4'd2;
         default:                        n = 4'd0;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/cpa_len_decode.sv
module cpa_len_decode
   import cpa_pkg::*;
(
   input  opc_t op,
   output len_t extra,
   output logic single
);
   assign extra  = cpa_extra_words(op);
   assign single = (extra == '0);
endmodule

// File: rtl/cpa_seq.sv
module cpa_seq
   import cpa_pkg::*;
#(
   parameter int unsigned MAX_WORDS = 12,
   localparam int unsigned IDX_W = $clog2(MAX_WORDS)
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             acc,
   input  logic             abort,
   input  len_t             extra,
   input  logic             single,
   output logic [IDX_W-1:0] pend_cnt,
   output logic [IDX_W-1:0] wr_idx,
   output logic             hdr_we,
   output logic             body_we,
   output logic             fire
);
   logic             idle;
   logic             last_body;
   logic             fire_d;
   logic [IDX_W-1:0] pend_q, idx_q;

   assign idle      = (pend_q == '0);
   assign hdr_we    = acc && (idle || abort);
   assign body_we   = acc && !idle && !abort;
   assign last_body = body_we && (pend_q == IDX_W'(1));
   assign fire_d    = (hdr_we && single) || last_body;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= '0;
         idx_q  <= '0;
         fire   <= 1'b0;
      end else begin
         fire <= fire_d;
         if (hdr_we) begin
            pend_q <= IDX_W'(extra);
            idx_q  <= single ? '0 : IDX_W'(1);
         end else if (body_we) begin
            pend_q <= pend_q - IDX_W'(1);
            idx_q  <= last_body ? '0 : idx_q + IDX_W'(1);
         end else if (abort) begin
            pend_q <= '0;
            idx_q  <= '0;
         end
      end
   end

   assign pend_cnt = pend_q;
   assign wr_idx   = idx_q;
endmodule

// File: rtl/cpa_buffer.sv
module cpa_buffer #(
   parameter int unsigned WORD_W      = 32,
   parameter int unsigned MAX_WORDS   = 12,
   parameter bit          CLEAR_STALE = 1'b1,
   localparam int unsigned IDX_W = $clog2(MAX_WORDS)
)(
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        hdr_we,
   input  logic                        body_we,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic [WORD_W-1:0]           din,
   output logic [MAX_WORDS*WORD_W-1:0] slots
);
   for (genvar k = 0; k < MAX_WORDS; k++) begin : g_slot
      logic [WORD_W-1:0] q;
      if (k == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst)         q <= '0;
            else if (hdr_we) q <= din;
         end
      end else begin : g_body
         logic clr;
         if (CLEAR_STALE) begin : g_clr
            assign clr = hdr_we;
         end else begin : g_keep
            assign clr = 1'b0;
         end
         always_ff @(posedge clk) begin
            if (rst)                                   q <= '0;
            else if (body_we && wr_idx == IDX_W'(k))   q <= din;
            else if (clr)                              q <= '0;
         end
      end
      assign slots[k*WORD_W +: WORD_W] = q;
   end
endmodule

// File: rtl/cmd_packet_assembler.sv
module cmd_packet_assembler
   import cpa_pkg::*;
#(
   parameter int unsigned WORD_W      = 32,
   parameter int unsigned MAX_WORDS   = 12,
   parameter bit          CLEAR_STALE = 1'b1,
   parameter logic [31:0] ABORT_KEY   = 32'h0400_0000
)(
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             in_valid,
   output logic                             in_ready,
   input  logic [WORD_W-1:0]                in_word,
   input  logic                             xfer_active,
   input  logic                             flush,
   input  logic                             ctl_valid,
   input  logic [31:0]                      ctl_arg,
   output logic                             div_valid,
   output logic [WORD_W-1:0]                div_word,
   output logic                             disp_valid,
   output logic [7:0]                       disp_opcode,
   output logic [$clog2(MAX_WORDS+1)-1:0]   disp_count,
   output logic [MAX_WORDS*WORD_W-1:0]      disp_words
);
   localparam int unsigned IDX_W = $clog2(MAX_WORDS);
   localparam int unsigned CNT_W = $clog2(MAX_WORDS+1);

   if (MAX_WORDS < 12) begin : g_chk_depth
      $error("MAX_WORDS must hold the longest packet (12 words)");
   end
   if (WORD_W < OPC_W + 1) begin : g_chk_width
      $error("WORD_W too narrow for an opcode field");
   end

   logic             take, acc, abort;
   opc_t             op;
   len_t             extra;
   logic             single;
   logic [IDX_W-1:0] pend_cnt, wr_idx;
   logic             hdr_we, body_we;
   opc_t             op_q;
   logic [CNT_W-1:0] cnt_q;

   assign in_ready  = !disp_valid;
   assign take      = in_valid && in_ready;
   assign acc       = take && !xfer_active;
   assign abort     = flush || (ctl_valid && ctl_arg == ABORT_KEY);
   assign div_valid = take && xfer_active;
   assign div_word  = in_word;
   assign op        = in_word[WORD_W-1 -: OPC_W];

   cpa_len_decode u_dec (
      .op     (op),
      .extra  (extra),
      .single (single)
   );

   cpa_seq #(.MAX_WORDS(MAX_WORDS)) u_seq (
      .clk      (clk),
      .rst      (rst),
      .acc      (acc),
      .abort    (abort),
      .extra    (extra),
      .single   (single),
      .pend_cnt (pend_cnt),
      .wr_idx   (wr_idx),
      .hdr_we   (hdr_we),
      .body_we  (body_we),
      .fire     (disp_valid)
   );

   cpa_buffer #(
      .WORD_W      (WORD_W),
      .MAX_WORDS   (MAX_WORDS),
      .CLEAR_STALE (CLEAR_STALE)
   ) u_buf (
      .clk     (clk),
      .rst     (rst),
      .hdr_we  (hdr_we),
      .body_we (body_we),
      .wr_idx  (wr_idx),
      .din     (in_word),
      .slots   (disp_words)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         op_q  <= '0;
         cnt_q <= '0;
      end else if (hdr_we) begin
         op_q  <= op;
         cnt_q <= CNT_W'(extra) + CNT_W'(1);
      end
   end

   assign disp_opcode = op_q;
   assign disp_count  = cnt_q;
endmodule

// File: rtl/cpa_checker.sv
module cpa_checker
   import cpa_pkg::*;
#(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned MAX_WORDS = 12,
   parameter logic [31:0] ABORT_KEY = 32'h0400_0000,
   localparam int unsigned IDX_W = $clog2(MAX_WORDS),
   localparam int unsigned CNT_W = $clog2(MAX_WORDS+1)
)(
   input logic                        clk,
   input logic                        rst,
   input logic                        in_valid,
   input logic                        in_ready,
   input logic [WORD_W-1:0]           in_word,
   input logic                        xfer_active,
   input logic                        flush,
   input logic                        ctl_valid,
   input logic [31:0]                 ctl_arg,
   input logic                        disp_valid,
   input logic [7:0]                  disp_opcode,
   input logic [CNT_W-1:0]            disp_count,
   input logic [MAX_WORDS*WORD_W-1:0] disp_words,
   input logic [IDX_W-1:0]            pend_cnt
);
   logic kill, asm_take, div_take;
   assign kill     = flush || (ctl_valid && ctl_arg == ABORT_KEY);
   assign asm_take = in_valid && in_ready && !xfer_active;
   assign div_take = in_valid && in_ready && xfer_active;

   // R5
   disp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      disp_valid |=> !disp_valid);

   // R5
   ready_low_chk: assert property (@(posedge clk) disable iff (rst)
      disp_valid |-> !in_ready);

   // R1
   opcode_slot0_chk: assert property (@(posedge clk) disable iff (rst)
      disp_valid |-> disp_opcode == disp_words[WORD_W-1 -: 8]);

   // R10
   count_chk: assert property (@(posedge clk) disable iff (rst)
      disp_valid |-> disp_count == CNT_W'(cpa_extra_words(disp_opcode)) + CNT_W'(1));

   // R8
   divert_chk: assert property (@(posedge clk) disable iff (rst)
      (div_take && !kill) |=> ($stable(pend_cnt) && !disp_valid));

   // R6
   abort_chk: assert property (@(posedge clk) disable iff (rst)
      (kill && !asm_take) |=> pend_cnt == '0);

   // R3
   zero_len_chk: assert property (@(posedge clk) disable iff (rst)
      (asm_take && (pend_cnt == '0 || kill) && cpa_extra_words(in_word[WORD_W-1 -: 8]) == '0)
      |=> (disp_valid && disp_count == CNT_W'(1)));
endmodule

bind cmd_packet_assembler cpa_checker #(
   .WORD_W    (WORD_W),
   .MAX_WORDS (MAX_WORDS),
   .ABORT_KEY (ABORT_KEY)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .in_word     (in_word),
   .xfer_active (xfer_active),
   .flush       (flush),
   .ctl_valid   (ctl_valid),
   .ctl_arg     (ctl_arg),
   .disp_valid  (disp_valid),
   .disp_opcode (disp_opcode),
   .disp_count  (disp_count),
   .disp_words  (disp_words),
   .pend_cnt    (pend_cnt)
);

// File: tb/cmd_packet_assembler_test.sv
module cmd_packet_assembler_test;
   localparam int CLK_PERIOD = 10;
   localparam int NW = 12;

   logic clk = 1'b0, rst = 1'b1;
   logic in_valid = 1'b0, xfer_active = 1'b0, flush = 1'b0, ctl_valid = 1'b0;
   logic [31:0] in_word = '0, ctl_arg = '0;
   logic in_ready, div_valid, disp_valid;
   logic [31:0] div_word;
   logic [7:0] disp_opcode;
   logic [3:0] disp_count;
   logic [NW*32-1:0] disp_words;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmd_packet_assembler uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
      .xfer_active(xfer_active), .flush(flush), .ctl_valid(ctl_valid), .ctl_arg(ctl_arg),
      .div_valid(div_valid), .div_word(div_word), .disp_valid(disp_valid),
      .disp_opcode(disp_opcode), .disp_count(disp_count), .disp_words(disp_words)
   );

   int checks = 0, errors = 0, disp_seen = 0, div_seen = 0;
   int last_op = -1;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // R2 reference lengths
   function automatic int ref_extra(input int op);
      int grp[8] = '{3, 6, 4, 8, 5, 8, 7, 11};
      if (op == 2) return 2;
      if (op >= 'h20 && op <= 'h3F) return grp[(op - 'h20) / 4];
      if (op >= 'h40 && op <= 'h43) return 2;
      if (op >= 'h48 && op <= 'h53) return 3;
      if (op >= 'h58 && op <= 'h5F) return 4;
      if (op >= 'h60 && op <= 'h63) return 2;
      if (op >= 'h64 && op <= 'h67) return 3;
      if (op >= 'h68 && op <= 'h7F) return ((op >> 2) & 1) ? 2 : 1;
      if (op == 'h80) return 3;
      if (op == 'hA0 || op == 'hC0) return 2;
      return 0;
   endfunction

   // behavioural reference model
   int m_pend = 0, m_idx = 0, m_op = 0, m_cnt = 0;
   bit m_disp = 0, m_init = 0;
   logic [31:0] m_buf[NW];

   always @(posedge clk) begin
      bit acc, ab, nd;
      int e;
      if (rst) begin
         m_pend = 0; m_idx = 0; m_disp = 0; m_op = 0; m_cnt = 0; m_init = 1;
         foreach (m_buf[k]) m_buf[k] = '0;
      end else if (m_init) begin
         acc = in_valid && !m_disp;
         ab  = flush || (ctl_valid && ctl_arg == 32'h0400_0000);
         nd  = 0;
         if (acc && !xfer_active) begin
            if (m_pend == 0 || ab) begin
               e = ref_extra(int'(in_word[31:24]));
               m_buf[0] = in_word;
               for (int k = 1; k < NW; k++) m_buf[k] = '0;
               m_op = int'(in_word[31:24]);
               m_cnt = e + 1;
               if (e == 0) begin nd = 1; m_pend = 0; m_idx = 0; end
               else begin m_pend = e; m_idx = 1; end
            end else begin
               m_buf[m_idx] = in_word;
               m_idx++;
               m_pend--;
               if (m_pend == 0) begin nd = 1; m_idx = 0; end
            end
         end else if (ab) begin
            m_pend = 0; m_idx = 0;
         end
         m_disp = nd;
      end
      #(CLK_PERIOD/4);
      if (m_init && !rst) begin
         bit exp_div;
         exp_div = in_valid && !m_disp && xfer_active;
         chk(in_ready == !m_disp, "R5 ready", in_ready, !m_disp);
         chk(disp_valid == m_disp, "R5 strobe", disp_valid, m_disp);
         chk(div_valid == exp_div, "R8 divert valid", div_valid, exp_div);
         if (exp_div) chk(div_word == in_word, "R8 divert word", div_word, in_word);
         if (disp_valid && m_disp) begin
            chk(disp_opcode == m_op, "R1 opcode", disp_opcode, m_op);
            chk(disp_count == m_cnt, "R10 count", disp_count, m_cnt);
            for (int k = 0; k < NW; k++)
               chk(disp_words[k*32 +: 32] == m_buf[k],
                   (k == 0) ? "R1 slot0" : ((k < m_cnt) ? "R4 slot" : "R11 stale slot"),
                   disp_words[k*32 +: 32], m_buf[k]);
         end
         if (disp_valid) begin disp_seen++; last_op = int'(disp_opcode); end
         if (div_valid) div_seen++;
      end
   end

   task automatic send(input logic [31:0] w);
      bit r;
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = w;
      forever begin
         r = in_ready;
         @(posedge clk);
         if (r) break;
         @(negedge clk);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(negedge clk); in_valid = 1'b0; end
   endtask

   task automatic body(input int n, input int tag);
      for (int i = 0; i < n; i++) send(32'hB000_0000 + tag * 16 + i);
   endtask

   task automatic pkt(input int op, input int tag);
      send({op[7:0], 24'(tag)});
      body(ref_extra(op), tag);
   endtask

   task automatic do_flush();
      @(negedge clk); in_valid = 1'b0; flush = 1'b1;
      @(negedge clk); flush = 1'b0;
   endtask

   task automatic flush_with(input logic [31:0] w);
      @(negedge clk); flush = 1'b1; in_valid = 1'b1; in_word = w;
      @(negedge clk); flush = 1'b0; in_valid = 1'b0;
   endtask

   task automatic ctl(input bit v, input logic [31:0] a);
      @(negedge clk); in_valid = 1'b0; ctl_valid = v; ctl_arg = a;
      @(negedge clk); ctl_valid = 1'b0;
   endtask

   task automatic set_xfer(input bit v);
      @(negedge clk); in_valid = 1'b0; xfer_active = v;
   endtask

   task automatic finish_run();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      int base, dv;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      // R9 reset state
      chk(in_ready == 1'b1, "R9 ready", in_ready, 1);
      chk(disp_valid == 1'b0, "R9 strobe", disp_valid, 0);
      chk(disp_words == '0, "R9 slots", longint'(|disp_words), 0);

      // R3 zero-length opcodes back to back
      base = disp_seen;
      send(32'hE100_0001); send(32'h0000_0002); send(32'h4400_0003);
      idle(3);
      chk(disp_seen == base + 3, "R3 single-word dispatches", disp_seen - base, 3);

      // R4 longest packet, then shorter one leaving stale slots
      base = disp_seen;
      pkt('h3C, 1); pkt('h20, 2); pkt('h68, 3);
      idle(3);
      chk(disp_seen == base + 3, "R4 multi-word dispatches", disp_seen - base, 3);

      // R6 flush mid packet, next word is a header
      base = disp_seen;
      send(32'h2C00_0010); body(3, 4);
      do_flush();
      pkt('h02, 5);
      idle(3);
      chk(disp_seen == base + 1, "R6 flush then new packet", disp_seen - base, 1);
      chk(last_op == 'h02, "R6 opcode after flush", last_op, 'h02);

      // R6 flush in the same cycle as an accepted word
      base = disp_seen;
      send(32'h2400_0020); body(2, 6);
      flush_with(32'h0200_00AA);
      body(2, 7);
      idle(3);
      chk(disp_seen == base + 1, "R6 coincident flush", disp_seen - base, 1);
      chk(last_op == 'h02, "R6 coincident header opcode", last_op, 'h02);

      // R7 near-miss key and key without strobe have no effect
      base = disp_seen;
      send(32'h2800_0030); body(1, 8);
      ctl(1'b1, 32'h0400_0001);
      ctl(1'b0, 32'h0400_0000);
      body(2, 9);
      idle(2);
      chk(disp_seen == base, "R7 ignored abort keeps pending", disp_seen - base, 0);
      body(1, 10);
      idle(3);
      chk(disp_seen == base + 1, "R7 packet completes", disp_seen - base, 1);
      chk(last_op == 'h28, "R7 completed opcode", last_op, 'h28);

      // R7 exact key aborts
      base = disp_seen;
      send(32'h2800_0040); body(1, 11);
      ctl(1'b1, 32'h0400_0000);
      send(32'h0100_0041);
      idle(3);
      chk(disp_seen == base + 1, "R7 key abort", disp_seen - base, 1);
      chk(last_op == 'h01, "R7 header after key abort", last_op, 'h01);

      // R8 image-transfer words bypass a pending packet
      base = disp_seen;
      dv = div_seen;
      send(32'h3000_0050); body(2, 12);
      set_xfer(1'b1);
      send(32'h2000_0000); send(32'h0000_0001); send(32'h3C00_0002); send(32'h0200_0003);
      set_xfer(1'b0);
      idle(2);
      chk(disp_seen == base, "R8 no dispatch from diverted words", disp_seen - base, 0);
      chk(div_seen == dv + 4, "R8 divert count", div_seen - dv, 4);
      body(3, 13);
      idle(3);
      chk(disp_seen == base + 1, "R8 packet resumes", disp_seen - base, 1);
      chk(last_op == 'h30, "R8 resumed opcode", last_op, 'h30);

      // R2 sweep of every opcode
      base = disp_seen;
      for (int op = 0; op < 256; op++) begin
         pkt(op, op);
         if (op % 3 == 0) idle(1);
      end
      idle(3);
      chk(disp_seen == base + 256, "R2 sweep dispatches", disp_seen - base, 256);

      finish_run();
   end
endmodule